// File: doc/BRIEF.md
# BCH t=32 Sector Parity Encoder

This block computes the parity of a systematic binary BCH code over GF(2^14) that corrects up to 32 bit errors in one NAND sector. A sector message is a byte stream of 1024 data bytes followed by 8 spare-area bytes, 1032 bytes in all. The stream arrives on a valid/ready input and its final byte carries a last flag. The block divides the message, taken as a polynomial multiplied by x^448, by the code's generator polynomial. After the final byte it returns the 448-bit remainder as 56 parity bytes on a valid/ready output. The message of 8256 bits makes this a shortened form of the length-16383 code, and the missing leading message bits count as zeros.

The generator polynomial is not stored as a table. It is worked out at elaboration from the field polynomial (x^14 + x^10 + x^6 + x + 1) and from t. Each distinct minimal polynomial of the odd powers alpha^1 to alpha^63 is formed, and these minimal polynomials are multiplied together. The division takes one byte per accepted cycle. Bits inside each byte are reversed on entry, and the parity bytes are reversed back when they leave.

Top module: `bch_sector_encoder`

## Requirements
- R1: When reset is released, `in_ready` is 1 and `par_valid` is 0.
- R2: A codeword is formed from the message bytes in arrival order, followed by the parity bytes in output order. Within every byte, bit 0 is taken first and bit 7 last, and the first bit taken is the highest-degree coefficient. This codeword has a zero value at alpha^j for every odd j from 1 to 63, where alpha is a root of x^14 + x^10 + x^6 + x + 1. So parity byte k carries remainder coefficient x^(447-8k) in bit 0 and x^(440-8k) in bit 7.
- R3: Each message produces exactly 56 parity bytes. `par_last` is 1 on the 56th parity byte and 0 on the others.
- R4: `in_ready` goes to 0 in the cycle after the byte flagged `in_last` is accepted. It stays 0 while `par_valid` is 1, and returns to 1 (with `par_valid` 0) in the cycle after the 56th parity byte is accepted.
- R5: While `par_valid` is 1 and `par_ready` is 0, `par_valid` stays 1 and `par_data` is unchanged in the next cycle.
- R6: The remainder starts from zero for every message. The parity of a message does not depend on the messages that came before it.
- R7: A message of all zero bytes gives 56 zero parity bytes.
- R8: Cycles with `in_valid` at 0 and cycles with `par_ready` at 0 do not change the parity bytes.
- R9: A message whose only 1 bit is bit 7 of its final byte gives parity bytes that are not all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A message byte is offered |
| in_ready | output | 1 | The encoder accepts a message byte |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | The offered byte ends the message |
| par_valid | output | 1 | A parity byte is offered |
| par_ready | input | 1 | The consumer takes the parity byte |
| par_data | output | 8 | Parity byte, highest remainder byte first |
| par_last | output | 1 | The offered parity byte is the final one |

## Verification
The 448-bit generator polynomial is never visible at the ports. The hardest behaviour to confirm is therefore that the remainder is correct, including the bit order within bytes and the order of the parity bytes. The bench does not rebuild the generator polynomial. It collects each full codeword and evaluates it at alpha^1, alpha^3, ... alpha^63 with its own GF(2^14) arithmetic, so any wrong bit order or wrong coefficient gives a nonzero value. The same data is also sent a second time with idle input cycles and output back-pressure mixed in, and after an unrelated message, to show that the parity does not change.

// File: rtl/bch_enc_pkg.sv
package bch_enc_pkg;

   localparam int GMAX = 1024;

   typedef enum logic {
      ENC_FEED = 1'b0,
      ENC_SEND = 1'b1
   } enc_state_t;

   // Product of two field elements, polynomial basis, modulus poly of degree m.
   function automatic int gf_mul(input int a, input int b, input int m, input int poly);
      int acc;
      int x;
      acc = 0;
      x   = a;
      for (int i = 0; i < m; i++) begin
         if (((b >> i) & 1) != 0) acc = acc ^ x;
         x = x << 1;
         if (((x >> m) & 1) != 0) x = x ^ poly;
      end
      return acc;
   endfunction

   // alpha^e with alpha = x, square-and-multiply.
   function automatic int gf_pow(input int e, input int m, input int poly);
      int res;
      int bse;
      res = 1;
      bse = 2;
      for (int i = 0; i < 20; i++) begin
         if (((e >> i) & 1) != 0) res = gf_mul(res, bse, m, poly);
         bse = gf_mul(bse, bse, m, poly);
      end
      return res;
   endfunction

   // Generator: product of the distinct minimal polynomials of alpha^1..alpha^(2t-1), odd.
   function automatic logic [GMAX:0] gen_poly(input int m, input int t, input int poly);
      logic [GMAX:0] g;
      logic [GMAX:0] prod;
      int n;
      int e;
      int deg;
      int r;
      bit fresh;
      bit done;
      int mp [0:16];
      g    = '0;
      g[0] = 1'b1;
      n    = (1 << m) - 1;
      for (int i = 1; i < 2 * t; i += 2) begin
         fresh = 1'b1;
         e     = i;
         for (int k = 0; k < m; k++) begin
            if (e < i) fresh = 1'b0;
            e = (e * 2) % n;
         end
         if (fresh) begin
            for (int k = 0; k < 17; k++) mp[k] = 0;
            mp[0] = 1;
            deg   = 0;
            e     = i;
            done  = 1'b0;
            for (int k = 0; k < m; k++) begin
               if (!done) begin
                  r = gf_pow(e, m, poly);
                  for (int j = 16; j > 0; j--) begin
                     if (j <= deg + 1) mp[j] = mp[j-1] ^ gf_mul(mp[j], r, m, poly);
                  end
                  mp[0] = gf_mul(mp[0], r, m, poly);
                  deg   = deg + 1;
                  e     = (e * 2) % n;
                  if (e == i) done = 1'b1;
               end
            end
            prod = '0;
            for (int k = 0; k < 17; k++) begin
               if (k <= deg && mp[k] != 0) prod = prod ^ (g << k);
            end
            g = prod;
         end
      end
      return g;
   endfunction

endpackage

// File: rtl/bch_bit_order.sv
module bch_bit_order #(
   parameter int W   = 8,
   parameter bit REV = 1'b1
) (
   input  logic [W-1:0] d_i,
   output logic [W-1:0] d_o
);

   generate
      if (REV) begin : g_rev
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign d_o[i] = d_i[W-1-i];
         end
      end else begin : g_pass
         assign d_o = d_i;
      end
   endgenerate

endmodule

// File: rtl/bch_byte_div.sv
module bch_byte_div #(
   parameter int            PB   = 448,
   parameter int            W    = 8,
   parameter logic [PB-1:0] GLOW = '0
) (
   input  logic [PB-1:0] rem_i,
   input  logic [W-1:0]  sym_i,   // sym_i[W-1] is the first bit into the division
   output logic [PB-1:0] rem_o
);

   logic [PB-1:0] acc;
   logic          fb;

   always_comb begin
      acc = rem_i;
      fb  = 1'b0;
      for (int b = W - 1; b >= 0; b--) begin
         fb  = sym_i[b] ^ acc[PB-1];
         acc = {acc[PB-2:0], 1'b0} ^ ({PB{fb}} & GLOW);
      end
      rem_o = acc;
   end

endmodule

// File: rtl/bch_sector_encoder.sv
module bch_sector_encoder #(
   parameter int M       = 14,
   parameter int T       = 32,
   parameter int POLY    = 17475,
   parameter bit BIT_REV = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   output logic       in_ready,
   input  logic [7:0] in_data,
   input  logic       in_last,
   output logic       par_valid,
   input  logic       par_ready,
   output logic [7:0] par_data,
   output logic       par_last
);
   import bch_enc_pkg::*;

   localparam int PB     = M * T;
   localparam int NBYTES = PB / 8;
   localparam int CW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;
   localparam logic [GMAX:0] GFULL = gen_poly(M, T, POLY);
   localparam logic [PB-1:0] GLOW  = GFULL[PB-1:0];

   generate
      if (M < 3 || M > 16) begin : g_bad_m
         $error("field degree out of range");
      end
      if (PB % 8 != 0 || PB > GMAX) begin : g_bad_pb
         $error("parity width must be a whole number of bytes within GMAX");
      end
      if (GFULL[PB] != 1'b1 || GFULL[0] != 1'b1 || (GFULL >> (PB + 1)) != '0) begin : g_bad_deg
         $error("generator degree differs from M*T");
      end
   endgenerate

   enc_state_t    state_q;
   logic [PB-1:0] rem_q;
   logic [PB-1:0] rem_nx;
   logic [CW-1:0] cnt_q;
   logic [7:0]    sym;
   logic          take_in;
   logic          give_out;
   logic          final_out;

   bch_bit_order #(.W(8), .REV(BIT_REV)) u_in_order (
      .d_i (in_data),
      .d_o (sym)
   );

   bch_byte_div #(.PB(PB), .W(8), .GLOW(GLOW)) u_div (
      .rem_i (rem_q),
      .sym_i (sym),
      .rem_o (rem_nx)
   );

   bch_bit_order #(.W(8), .REV(BIT_REV)) u_out_order (
      .d_i (rem_q[PB-1 -: 8]),
      .d_o (par_data)
   );

   assign in_ready  = (state_q == ENC_FEED);
   assign par_valid = (state_q == ENC_SEND);
   assign par_last  = par_valid && (cnt_q == CW'(NBYTES - 1));
   assign take_in   = in_valid && in_ready;
   assign give_out  = par_valid && par_ready;
   assign final_out = give_out && par_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ENC_FEED;
         rem_q   <= '0;
         cnt_q   <= '0;
      end else if (take_in) begin
         rem_q <= rem_nx;
         cnt_q <= '0;
         if (in_last) state_q <= ENC_SEND;
      end else if (give_out) begin
         if (final_out) begin
            rem_q   <= '0;
            cnt_q   <= '0;
            state_q <= ENC_FEED;
         end else begin
            rem_q <= {rem_q[PB-9:0], 8'h00};
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R4
   in_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      par_valid |-> !in_ready);
   // R4
   last_enters_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> (par_valid && !in_ready));
   // R4
   reopen_after_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (par_valid && par_ready && par_last) |=> (in_ready && !par_valid));
   // R5
   par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (par_valid && !par_ready) |=> (par_valid && $stable(par_data) && $stable(par_last)));
   // R6
   rem_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (par_valid && par_ready && par_last) |=> (rem_q == '0));
   // R3
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      par_valid |-> (cnt_q <= CW'(NBYTES - 1)));

endmodule

// File: tb/bch_sector_encoder_tb.sv
module bch_sector_encoder_tb;

   localparam int CLK_PERIOD = 10;
   localparam int MSG_BYTES  = 1032;
   localparam int PAR_BYTES  = 56;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_data = '0;
   logic       in_last = 1'b0;
   logic       par_valid;
   logic       par_ready = 1'b0;
   logic [7:0] par_data;
   logic       par_last;

   int n_total = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [7:0] msg  [MSG_BYTES];
   logic [7:0] par  [PAR_BYTES];
   logic [7:0] keep [PAR_BYTES];
   logic [31:0] rng = 32'h1badf00d;

   always #(CLK_PERIOD / 2) clk = ~clk;

   bch_sector_encoder u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .in_last   (in_last),
      .par_valid (par_valid),
      .par_ready (par_ready),
      .par_data  (par_data),
      .par_last  (par_last)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int fmul(input int a, input int b);
      int acc = 0;
      int x = a;
      for (int i = 0; i < 14; i++) begin
         if (((b >> i) & 1) != 0) acc ^= x;
         x = x << 1;
         if ((x & 16'h4000) != 0) x ^= 16'h4443;
      end
      return acc;
   endfunction

   // Number of odd j in 1..63 where the codeword does not vanish at alpha^j.
   function automatic int bad_roots();
      int nbad = 0;
      for (int j = 1; j < 64; j += 2) begin
         int aj = 1;
         int s  = 0;
         for (int k = 0; k < j; k++) aj = fmul(aj, 2);
         for (int idx = 0; idx < MSG_BYTES + PAR_BYTES; idx++) begin
            logic [7:0] b;
            b = (idx < MSG_BYTES) ? msg[idx] : par[idx - MSG_BYTES];
            for (int bit_i = 0; bit_i < 8; bit_i++) s = fmul(s, aj) ^ int'(b[bit_i]);
         end
         if (s != 0) nbad++;
      end
      return nbad;
   endfunction

   function automatic int par_diff();
      int d = 0;
      for (int k = 0; k < PAR_BYTES; k++) if (par[k] !== keep[k]) d++;
      return d;
   endfunction

   function automatic int par_nonzero();
      int d = 0;
      for (int k = 0; k < PAR_BYTES; k++) if (par[k] != 8'h00) d++;
      return d;
   endfunction

   task automatic push(input logic [7:0] d, input logic l);
      in_valid = 1'b1;
      in_data  = d;
      in_last  = l;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic send_msg(input bit gaps);
      for (int i = 0; i < MSG_BYTES; i++) begin
         if (gaps && (i % 5 == 2)) repeat (2) @(negedge clk);
         push(msg[i], (i == MSG_BYTES - 1));
      end
   endtask

   task automatic pull(input bit bp);
      int got = 0;
      int guard = 0;
      logic [7:0] held = '0;
      bit holding = 1'b0;
      bit r4ok = 1'b1;
      bit r5ok = 1'b1;
      bit lastok = 1'b1;
      while (got < PAR_BYTES && guard < 4000) begin
         if (par_valid && in_ready) r4ok = 1'b0;
         if (holding && (!par_valid || par_data !== held)) r5ok = 1'b0;
         par_ready = bp ? (((got + guard) % 3) != 0) : 1'b1;
         if (par_valid) begin
            if (par_ready) begin
               par[got] = par_data;
               if (par_last !== (got == PAR_BYTES - 1)) lastok = 1'b0;
               got++;
               holding = 1'b0;
            end else begin
               holding = 1'b1;
               held    = par_data;
            end
         end
         @(negedge clk);
         guard++;
      end
      par_ready = 1'b0;
      chk(got == PAR_BYTES, "R3 parity byte count", got, PAR_BYTES);
      chk(lastok, "R3 par_last position", int'(lastok), 1);
      chk(r4ok, "R4 in_ready low while sending", int'(r4ok), 1);
      chk(in_ready === 1'b1 && par_valid === 1'b0, "R4 reopen after last parity byte",
          int'({in_ready, par_valid}), 2);
      if (bp) chk(r5ok, "R5 parity held under back-pressure", int'(r5ok), 1);
   endtask

   task automatic fill_random();
      for (int i = 0; i < MSG_BYTES; i++) begin
         rng = rng ^ (rng << 13);
         rng = rng ^ (rng >> 17);
         rng = rng ^ (rng << 5);
         msg[i] = rng[7:0];
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready === 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
      chk(par_valid === 1'b0, "R1 par_valid after reset", int'(par_valid), 0);
   endtask

   task automatic t_zero();
      for (int i = 0; i < MSG_BYTES; i++) msg[i] = 8'h00;
      send_msg(1'b0);
      pull(1'b0);
      chk(par_nonzero() == 0, "R7 zero message zero parity", par_nonzero(), 0);
   endtask

   task automatic t_ramp();
      for (int i = 0; i < MSG_BYTES; i++) msg[i] = 8'(i * 7 + 3);
      send_msg(1'b0);
      pull(1'b0);
      chk(bad_roots() == 0, "R2 ramp codeword roots", bad_roots(), 0);
      for (int k = 0; k < PAR_BYTES; k++) keep[k] = par[k];
   endtask

   task automatic t_single();
      for (int i = 0; i < MSG_BYTES; i++) msg[i] = 8'h00;
      msg[MSG_BYTES - 1] = 8'h80;
      send_msg(1'b0);
      pull(1'b0);
      chk(bad_roots() == 0, "R2 single-bit codeword roots", bad_roots(), 0);
      chk(par_nonzero() != 0, "R9 single-bit parity nonzero", par_nonzero(), 1);
   endtask

   task automatic t_gaps();
      fill_random();
      send_msg(1'b0);
      pull(1'b0);
      chk(bad_roots() == 0, "R2 random codeword roots", bad_roots(), 0);
      for (int k = 0; k < PAR_BYTES; k++) keep[k] = par[k];
      send_msg(1'b1);
      pull(1'b1);
      chk(par_diff() == 0, "R8 gaps and back-pressure leave parity unchanged", par_diff(), 0);
   endtask

   task automatic t_back_to_back();
      for (int i = 0; i < MSG_BYTES; i++) msg[i] = 8'(i * 7 + 3);
      send_msg(1'b0);
      pull(1'b0);
      for (int k = 0; k < PAR_BYTES; k++) keep[k] = par[k];
      fill_random();
      send_msg(1'b0);
      pull(1'b0);
      for (int i = 0; i < MSG_BYTES; i++) msg[i] = 8'(i * 7 + 3);
      send_msg(1'b0);
      pull(1'b1);
      chk(par_diff() == 0, "R6 parity independent of previous message", par_diff(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_total++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_zero();
      t_ramp();
      t_single();
      t_gaps();
      t_back_to_back();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

endmodule